// File: doc/BRIEF.md
# Dual-Channel Pulse Length Modulator

Two independent modulated outputs, A and B, each built from a frame counter and an 8-bit duty value. Every frame the output is driven high for a stretch proportional to the channel's value and low for the rest of the frame. The counter advances only on cycles where the shared timer tick enable is high, so frame lengths are measured in timer ticks rather than clock cycles.

Each channel has its own mode input that chooses the frame length. The fast mode gives a 256-tick frame, and the slow mode gives a 4096-tick frame, sixteen times longer. The mode input acts at once, with no buffering. Software is expected to settle the mode before it writes a value. The duty value is double buffered: a write goes into a holding register, and that register is copied into the active register at the channel's next frame boundary.

Top module: `plm_dual`

## Requirements
- R1: While reset is high, and on the first cycles after it, both outputs are low. Reset clears both frame counters, both holding registers and both active duty values to zero.
- R2: When a channel's mode input is 0 (fast), its frame lasts 256 ticks and the output is high for exactly `value` ticks per frame. Those are the first `value` ticks of the frame.
- R3: When a channel's mode input is 1 (slow), its frame lasts 4096 ticks and the output is high for `value`×16 ticks at the start of each frame.
- R4: An active value of zero holds the output low for the whole frame.
- R5: A write on `wr_a` or `wr_b` with `wr_data` changes only the holding register. The new value reaches the output only after the channel's next frame boundary. A write in the same cycle as a boundary tick is applied at the boundary after that one.
- R6: On a cycle where `tick_en` is 0, neither frame counter advances and no frame boundary occurs.
- R7: A write strobe or mode input of one channel has no effect on the other channel's output.
- R8: The mode input is not buffered and acts from the next tick. In fast mode, a frame ends whenever the low 8 bits of the counter reach 255. In slow mode, a frame ends only when the full 12-bit count reaches 4095. Output in the frame that is cut short by a mode change may be wrong.
- R9: Each output is registered. It shows the comparison of the counter and active value as they stood one clock earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Timer tick enable; counters advance only when high |
| wr_a | input | 1 | Write strobe for channel A holding register |
| wr_b | input | 1 | Write strobe for channel B holding register |
| wr_data | input | 8 | Duty value written by either strobe |
| slow_a | input | 1 | Channel A mode: 0 fast (256 ticks), 1 slow (4096 ticks) |
| slow_b | input | 1 | Channel B mode: 0 fast (256 ticks), 1 slow (4096 ticks) |
| pwm_a | output | 1 | Channel A modulated output |
| pwm_b | output | 1 | Channel B modulated output |

## Verification
A behavioural model in the bench steps every rising edge: it takes the expected output from the count and active value held before the edge, then applies the tick, any boundary load, and the write. That expected value is due one clock after the state it depends on. It is compared with the design on the following falling edge, so the single register stage of R9 is accounted for on every cycle. A write reaches the output only one full frame boundary plus one clock later. The windowed duty checks therefore begin only after two whole frames have passed since the last write, and each then counts high cycles over exactly one frame length.

// File: rtl/plm_pkg.sv
package plm_pkg;
  typedef enum logic {
    MODE_FAST = 1'b0,
    MODE_SLOW = 1'b1
  } plm_mode_e;

  localparam int unsigned DEF_VAL_W      = 8;
  localparam int unsigned DEF_SLOW_SHIFT = 4;
endpackage

// File: rtl/plm_frame_ctr.sv
module plm_frame_ctr #(
  parameter int unsigned VAL_W      = plm_pkg::DEF_VAL_W,
  parameter int unsigned SLOW_SHIFT = plm_pkg::DEF_SLOW_SHIFT,
  localparam int unsigned CW        = VAL_W + SLOW_SHIFT
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          slow,
  output logic [CW-1:0] cnt,
  output logic          wrap
);
  localparam logic [CW-1:0] FAST_LEN = CW'(1) << VAL_W;

  logic end_fast, end_slow;

  // Frame end depends on the live mode bit (unbuffered).
  assign end_fast = &cnt[VAL_W-1:0];
  assign end_slow = &cnt;
  assign wrap     = tick && ((slow == plm_pkg::MODE_SLOW) ? end_slow : end_fast);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (wrap) cnt <= '0;
    else if (tick) cnt <= cnt + 1'b1;
  end

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt));

  assert_fast_bound_R2: assert property (@(posedge clk) disable iff (rst)
    (!slow && cnt < FAST_LEN) |=> cnt < FAST_LEN);
endmodule

// File: rtl/plm_chan.sv
module plm_chan #(
  parameter int unsigned VAL_W      = plm_pkg::DEF_VAL_W,
  parameter int unsigned SLOW_SHIFT = plm_pkg::DEF_SLOW_SHIFT,
  localparam int unsigned CW        = VAL_W + SLOW_SHIFT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [VAL_W-1:0] wr_data,
  input  logic             slow,
  input  logic [CW-1:0]    cnt,
  input  logic             wrap,
  output logic             pwm
);
  logic [VAL_W-1:0] hold_q;
  logic [VAL_W-1:0] active_q;
  logic             hit;

  // Slow mode compares the coarse count, i.e. value x 2^SLOW_SHIFT ticks.
  always_comb begin
    if (slow == plm_pkg::MODE_SLOW) hit = cnt[CW-1:SLOW_SHIFT] < active_q;
    else                            hit = cnt < {{SLOW_SHIFT{1'b0}}, active_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q   <= '0;
      active_q <= '0;
      pwm      <= 1'b0;
    end else begin
      if (wr)   hold_q   <= wr_data;
      if (wrap) active_q <= hold_q;
      pwm <= hit;
    end
  end

  assert_buffered_R5: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(active_q));

  assert_zero_low_R4: assert property (@(posedge clk) disable iff (rst)
    (active_q == '0) |=> !pwm);
endmodule

// File: rtl/plm_dual.sv
module plm_dual #(
  parameter int unsigned VAL_W      = plm_pkg::DEF_VAL_W,
  parameter int unsigned SLOW_SHIFT = plm_pkg::DEF_SLOW_SHIFT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             wr_a,
  input  logic             wr_b,
  input  logic [VAL_W-1:0] wr_data,
  input  logic             slow_a,
  input  logic             slow_b,
  output logic             pwm_a,
  output logic             pwm_b
);
  localparam int unsigned NCH = 2;
  localparam int unsigned CW  = VAL_W + SLOW_SHIFT;

  logic [NCH-1:0] wr_v, slow_v, pwm_v, wrap_v;
  logic [CW-1:0]  cnt_v [NCH];

  assign wr_v   = {wr_b, wr_a};
  assign slow_v = {slow_b, slow_a};
  assign pwm_a  = pwm_v[0];
  assign pwm_b  = pwm_v[1];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    plm_frame_ctr #(.VAL_W(VAL_W), .SLOW_SHIFT(SLOW_SHIFT)) ctr_i (
      .clk (clk),
      .rst (rst),
      .tick(tick_en),
      .slow(slow_v[c]),
      .cnt (cnt_v[c]),
      .wrap(wrap_v[c])
    );

    plm_chan #(.VAL_W(VAL_W), .SLOW_SHIFT(SLOW_SHIFT)) chan_i (
      .clk    (clk),
      .rst    (rst),
      .wr     (wr_v[c]),
      .wr_data(wr_data),
      .slow   (slow_v[c]),
      .cnt    (cnt_v[c]),
      .wrap   (wrap_v[c]),
      .pwm    (pwm_v[c])
    );
  end
endmodule

// File: tb/plm_dual_tb.sv
`timescale 1ns/1ps
module plm_dual_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_en = 1'b0;
  logic       wr_a = 1'b0, wr_b = 1'b0;
  logic [7:0] wr_data = '0;
  logic       slow_a = 1'b0, slow_b = 1'b0;
  logic       pwm_a, pwm_b;

  int    n_checks = 0;
  int    n_errs   = 0;
  int    cycles   = 0;
  string cur_req  = "R1";
  bit    done     = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  plm_dual dut_i (
    .clk(clk), .rst(rst), .tick_en(tick_en),
    .wr_a(wr_a), .wr_b(wr_b), .wr_data(wr_data),
    .slow_a(slow_a), .slow_b(slow_b),
    .pwm_a(pwm_a), .pwm_b(pwm_b)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // Behavioural reference: position in frame, active and held duty per channel.
  int pos [2];
  int act [2];
  int hold[2];
  bit expv[2];

  always @(posedge clk) begin
    cycles++;
    for (int c = 0; c < 2; c++) begin
      bit s;
      bit w;
      s = (c == 0) ? slow_a : slow_b;
      w = (c == 0) ? wr_a : wr_b;
      if (rst) begin
        pos[c] = 0; act[c] = 0; hold[c] = 0; expv[c] = 0;
      end else begin
        expv[c] = ((s ? pos[c] / 16 : pos[c]) < act[c]);
        if (tick_en) begin
          if (s ? (pos[c] == 4095) : (pos[c] % 256 == 255)) begin
            pos[c] = 0;
            act[c] = hold[c];
          end else begin
            pos[c] = (pos[c] + 1) % 4096;
          end
        end
        if (w) hold[c] = int'(wr_data);
      end
    end
  end

  // Every-clock comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (!done && cycles > 0) begin
      check(pwm_a === expv[0], {cur_req, " chA per-cycle (R9)"}, int'(pwm_a), int'(expv[0]));
      check(pwm_b === expv[1], {cur_req, " chB per-cycle (R9)"}, int'(pwm_b), int'(expv[1]));
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input bit chb, input logic [7:0] v);
    wr_data = v;
    if (chb) wr_b = 1'b1; else wr_a = 1'b1;
    cyc(1);
    wr_a = 1'b0; wr_b = 1'b0;
  endtask

  task automatic count_high(input bit chb, input int n, output int hi);
    hi = 0;
    repeat (n) begin
      @(negedge clk);
      if (chb ? pwm_b : pwm_a) hi++;
    end
    #1;
  endtask

  initial begin : watchdog
    wait (cycles > 190000);
    n_errs++; n_checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 0);
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin : stim
    int hi;
    cyc(5);
    check(!pwm_a && !pwm_b, "R1 outputs low in reset", int'(pwm_a | pwm_b), 0);
    rst = 1'b0; tick_en = 1'b1;
    cyc(300);
    cur_req = "R4";
    check(!pwm_a && !pwm_b, "R1 low after reset", int'(pwm_a | pwm_b), 0);

    // Fast A = 100, slow B = 10
    cur_req = "R2";
    slow_b = 1'b1;
    wr(1'b0, 8'd100);
    cur_req = "R3";
    wr(1'b1, 8'd10);
    cyc(2 * 4096 + 10);
    count_high(1'b0, 256, hi);
    check(hi == 100, "R2 fast high ticks", hi, 100);
    count_high(1'b1, 4096, hi);
    check(hi == 160, "R3 slow high ticks", hi, 160);

    // Double buffering: mid-frame write on A
    cur_req = "R5";
    cyc(37);
    wr(1'b0, 8'd200);
    cyc(600);
    count_high(1'b0, 256, hi);
    check(hi == 200, "R5 new value after boundary", hi, 200);

    // Independence: write only B, A stays at 200
    cur_req = "R7";
    wr(1'b1, 8'd3);
    count_high(1'b0, 256, hi);
    check(hi == 200, "R7 A unaffected by B write", hi, 200);

    // Tick gating
    cur_req = "R6";
    tick_en = 1'b0;
    cyc(80);
    for (int i = 0; i < 3000; i++) begin
      tick_en = ($urandom % 3) != 0;
      cyc(1);
    end
    tick_en = 1'b1;

    // Zero and full values
    cur_req = "R4";
    wr(1'b0, 8'd0);
    cyc(600);
    count_high(1'b0, 256, hi);
    check(hi == 0, "R4 zero value low", hi, 0);
    cur_req = "R2";
    wr(1'b0, 8'd255);
    cyc(600);
    count_high(1'b0, 256, hi);
    check(hi == 255, "R2 full value", hi, 255);

    // Unbuffered mode switch mid-frame
    cur_req = "R8";
    cyc(90);
    slow_a = 1'b1; slow_b = 1'b0;
    cyc(10000);
    count_high(1'b0, 4096, hi);
    check(hi == 255 * 16, "R8 A now slow", hi, 4080);
    count_high(1'b1, 256, hi);
    check(hi == 3, "R8 B now fast", hi, 3);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule